// File: doc/BRIEF.md
# Audio Frame Synchronization Generator

This block produces the frame synchronization (FS) strobe of a serial audio port operating as the clock master. It runs in the system clock domain. A single-cycle bit-clock enable (`sck_tick`) marks each serial bit period. The block counts bit positions inside each audio frame and exposes the current position. It flags the first bit of every frame and drives FS with a programmable active width, level and one-bit lead.

In channel-identification mode, FS covers the first half of the frame, which is the left channel. The `chan_right` output then reports when the second half, the right channel, is in progress. All settings are sampled once, on the rising edge of `blk_en`. Changes to the configuration inputs while the block is enabled have no effect until the next enable. When disabled, FS rests at its inactive level and the position counter stays at zero.

Top module: `fsync_gen`

## Requirements
- R1: The frame holds N = max(`cfg_frame_len`, 7) + 1 bit positions. `bit_idx` starts at 0 in the first cycle after the enable rising edge. It advances by one only in cycles where `sck_tick` is 1, and wraps from N-1 to 0.
- R2: A programmed `cfg_frame_len` below 7 behaves exactly like 7, so a frame is never shorter than 8 bits.
- R3: With `cfg_offset` = 0 and `cfg_chan_mode` = 0, FS is active while `bit_idx` < W, where W = `cfg_act_len` + 1 (subject to R4).
- R4: W is limited to N-1, so at least one inactive bit remains in every frame. With `cfg_offset` = 0, FS is always inactive at bit N-1.
- R5: `cfg_pol_high` = 1 makes the active level high. `cfg_pol_high` = 0 makes the active level low.
- R6: With `cfg_offset` = 1, the active window starts one bit earlier. FS is active at bit N-1 and at bits below W-1. In the first frame after enable, the window therefore begins at bit 0 and lasts W-1 bits.
- R7: With `cfg_chan_mode` = 1, W = floor(N/2) and `cfg_act_len` is not used. `chan_right` is 1 while `bit_idx` >= floor(N/2). With `cfg_chan_mode` = 0, `chan_right` stays 0.
- R8: `sof` is 1 exactly in cycles where the block is running, `bit_idx` = 0 and `sck_tick` = 1.
- R9: Configuration inputs are captured only in the cycle where `blk_en` rises. Changes made while `blk_en` stays 1 have no effect on any output.
- R10: While disabled, FS sits at the inactive level of the last captured polarity (low after reset), and `bit_idx`, `sof` and `chan_right` are 0. The running state ends in the cycle after `blk_en` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sck_tick | input | 1 | Bit-clock enable, one pulse per serial bit |
| blk_en | input | 1 | Audio block enable; its rising edge captures configuration |
| cfg_frame_len | input | 8 | Frame length minus one, in bits |
| cfg_act_len | input | 7 | FS active width minus one, in bits |
| cfg_chan_mode | input | 1 | 1: FS marks the left half-frame |
| cfg_pol_high | input | 1 | 1: FS active high; 0: active low |
| cfg_offset | input | 1 | 1: FS leads the frame by one bit |
| fs | output | 1 | Frame synchronization output |
| bit_idx | output | 8 | Bit position inside the current frame |
| sof | output | 1 | Start-of-frame strobe |
| chan_right | output | 1 | High during the right-channel half of the frame |

## Verification
On every cycle, the assertions check four things. The counter wraps at the frame end and holds between bit-clock ticks. It clears while the block is disabled. The captured configuration never moves during an enabled stretch. FS is inactive on the last bit and in the right half of a channel-mode frame when there is no offset. The exact FS waveform for each combination of width, polarity, lead and channel mode can only be shown by the bench scenarios. The same holds for the clamping of short frames and over-long widths, the gated tick pattern, and the mid-run configuration change that must be ignored. The bench compares each of these cycle by cycle against values worked out from the requirements.

// File: rtl/fsync_pkg.sv
package fsync_pkg;

    parameter int LEN_W    = 8;
    parameter int ACT_W    = 7;
    parameter int MIN_BITS = 8;

    localparam int N_W = LEN_W + 1;

    typedef logic [LEN_W-1:0] bitpos_t;
    typedef logic [N_W-1:0]   span_t;

    typedef struct packed {
        bitpos_t            frame_len;
        logic [ACT_W-1:0]   act_len;
        logic               chan_mode;
        logic               pol_high;
        logic               early;
    } fs_cfg_t;

    localparam fs_cfg_t CFG_RESET = '{
        frame_len: bitpos_t'(MIN_BITS - 1),
        act_len:   '0,
        chan_mode: 1'b0,
        pol_high:  1'b1,
        early:     1'b0
    };

    // Number of bit positions per frame, never below MIN_BITS.
    function automatic span_t frame_bits(bitpos_t len);
        bitpos_t floor_v;
        bitpos_t use_v;
        floor_v = bitpos_t'(MIN_BITS - 1);
        use_v   = (len < floor_v) ? floor_v : len;
        return span_t'(use_v) + span_t'(1);
    endfunction

    // Active FS width, limited so one inactive bit always remains.
    function automatic span_t active_width(fs_cfg_t c, span_t n);
        span_t raw;
        span_t lim;
        lim = n - span_t'(1);
        if (c.chan_mode)
            raw = n >> 1;
        else
            raw = span_t'(c.act_len) + span_t'(1);
        return (raw > lim) ? lim : raw;
    endfunction

endpackage

// File: rtl/fsync_shadow.sv
module fsync_shadow
    import fsync_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    blk_en,
    input  fs_cfg_t cfg_in,
    output fs_cfg_t cfg_q,
    output logic    run
);

    logic rise;
    assign rise = blk_en & ~run;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
            run   <= 1'b0;
        end else begin
            run <= blk_en;
            if (rise)
                cfg_q <= cfg_in;
        end
    end

    // R9: settings frozen throughout an enabled stretch
    a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        (blk_en && run) |=> $stable(cfg_q));

endmodule

// File: rtl/fsync_counter.sv
module fsync_counter
    import fsync_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    blk_en,
    input  logic    run,
    input  logic    tick,
    input  span_t   last,
    output bitpos_t cnt
);

    logic at_end;
    assign at_end = (span_t'(cnt) == last);

    always_ff @(posedge clk) begin
        if (rst || !blk_en)
            cnt <= '0;
        else if (run && tick)
            cnt <= at_end ? '0 : cnt + bitpos_t'(1);
    end

    // R1: wrap after the final bit of the frame
    a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
        (blk_en && run && tick && at_end) |=> (cnt == '0));

    // R1: position holds between bit-clock ticks
    a_r1_hold: assert property (@(posedge clk) disable iff (rst)
        (blk_en && run && !tick) |=> $stable(cnt));

    // R10: counter parked at zero while disabled
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !blk_en |=> (cnt == '0));

endmodule

// File: rtl/fsync_decode.sv
module fsync_decode
    import fsync_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  fs_cfg_t cfg,
    input  logic    run,
    input  logic    tick,
    input  bitpos_t cnt,
    output span_t   last,
    output logic    fs_o,
    output logic    sof_o,
    output logic    chan_right_o
);

    span_t n_bits;
    span_t width;
    span_t half;
    span_t pos_now;
    span_t pos_lead;
    logic  in_window;

    assign n_bits  = frame_bits(cfg.frame_len);
    assign last    = n_bits - span_t'(1);
    assign width   = active_width(cfg, n_bits);
    assign half    = n_bits >> 1;
    assign pos_now = span_t'(cnt);

    // With the lead enabled, the final bit maps onto window position 0.
    always_comb begin
        if (cfg.early)
            pos_lead = (pos_now == last) ? '0 : pos_now + span_t'(1);
        else
            pos_lead = pos_now;
    end

    assign in_window    = run && (pos_lead < width);
    assign fs_o         = in_window ? cfg.pol_high : ~cfg.pol_high;
    assign sof_o        = run && tick && (cnt == '0);
    assign chan_right_o = run && cfg.chan_mode && (pos_now >= half);

    // R4: final bit of the frame is never active without lead
    a_r4_last_bit_idle: assert property (@(posedge clk) disable iff (rst)
        (run && !cfg.early && pos_now == last) |-> (fs_o == ~cfg.pol_high));

    // R7: right half-frame never shows the active level without lead
    a_r7_right_idle: assert property (@(posedge clk) disable iff (rst)
        (chan_right_o && !cfg.early) |-> (fs_o == ~cfg.pol_high));

endmodule

// File: rtl/fsync_gen.sv
module fsync_gen
    import fsync_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sck_tick,
    input  logic             blk_en,
    input  logic [LEN_W-1:0] cfg_frame_len,
    input  logic [ACT_W-1:0] cfg_act_len,
    input  logic             cfg_chan_mode,
    input  logic             cfg_pol_high,
    input  logic             cfg_offset,
    output logic             fs,
    output logic [LEN_W-1:0] bit_idx,
    output logic             sof,
    output logic             chan_right
);

    fs_cfg_t cfg_in;
    fs_cfg_t cfg_q;
    logic    run;
    bitpos_t cnt;
    span_t   last;

    assign cfg_in = '{
        frame_len: cfg_frame_len,
        act_len:   cfg_act_len,
        chan_mode: cfg_chan_mode,
        pol_high:  cfg_pol_high,
        early:     cfg_offset
    };

    fsync_shadow u_shadow (
        .clk    (clk),
        .rst    (rst),
        .blk_en (blk_en),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q),
        .run    (run)
    );

    fsync_counter u_counter (
        .clk    (clk),
        .rst    (rst),
        .blk_en (blk_en),
        .run    (run),
        .tick   (sck_tick),
        .last   (last),
        .cnt    (cnt)
    );

    fsync_decode u_decode (
        .clk          (clk),
        .rst          (rst),
        .cfg          (cfg_q),
        .run          (run),
        .tick         (sck_tick),
        .cnt          (cnt),
        .last         (last),
        .fs_o         (fs),
        .sof_o        (sof),
        .chan_right_o (chan_right)
    );

    assign bit_idx = cnt;

endmodule

// File: tb/fsync_gen_bench.sv
`timescale 1ns/1ps
module fsync_gen_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sck_tick = 1'b0;
    logic       blk_en = 1'b0;
    logic [7:0] cfg_frame_len = 8'd0;
    logic [6:0] cfg_act_len = 7'd0;
    logic       cfg_chan_mode = 1'b0;
    logic       cfg_pol_high = 1'b1;
    logic       cfg_offset = 1'b0;
    logic       fs;
    logic [7:0] bit_idx;
    logic       sof;
    logic       chan_right;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fsync_gen u_fsync_gen (
        .clk           (clk),
        .rst           (rst),
        .sck_tick      (sck_tick),
        .blk_en        (blk_en),
        .cfg_frame_len (cfg_frame_len),
        .cfg_act_len   (cfg_act_len),
        .cfg_chan_mode (cfg_chan_mode),
        .cfg_pol_high  (cfg_pol_high),
        .cfg_offset    (cfg_offset),
        .fs            (fs),
        .bit_idx       (bit_idx),
        .sof           (sof),
        .chan_right    (chan_right)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int frame_n(input int len);
        return ((len < 7) ? 7 : len) + 1;
    endfunction

    function automatic int win_w(input int n, input int a, input bit ch);
        int w;
        w = ch ? n / 2 : a + 1;
        if (w > n - 1) w = n - 1;
        return w;
    endfunction

    function automatic int exp_fs(input int k, input int n, input int w,
                                  input bit early, input bit pol);
        int pos;
        bit on;
        pos = early ? ((k == n - 1) ? 0 : k + 1) : k;
        on  = (pos < w);
        return pol ? int'(on) : int'(!on);
    endfunction

    // Enable with the given settings, then check every cycle.
    task automatic run_cfg(input int len, input int a, input bit ch, input bit pol,
                           input bit early, input int cycles, input bit gapped,
                           input bit mid_change, input string tag);
        int n;
        int w;
        int k;
        @(negedge clk);
        blk_en = 1'b0;
        repeat (2) @(negedge clk);
        cfg_frame_len = 8'(len);
        cfg_act_len   = 7'(a);
        cfg_chan_mode = ch;
        cfg_pol_high  = pol;
        cfg_offset    = early;
        sck_tick      = 1'b1;
        blk_en        = 1'b1;
        n = frame_n(len);
        w = win_w(n, a, ch);
        k = 0;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            if (mid_change && c == 5) begin
                // R9: inputs change while enabled; expectations stay on the first set
                cfg_frame_len = 8'd63;
                cfg_act_len   = 7'd30;
                cfg_chan_mode = 1'b1;
                cfg_pol_high  = ~pol;
                cfg_offset    = ~early;
            end
            sck_tick = gapped ? ((c % 3) != 1) : 1'b1;
            #1;
            check("R1 bit_idx", int'(bit_idx), k);
            check({tag, " fs"}, int'(fs), exp_fs(k, n, w, early, pol));
            check("R8 sof", int'(sof), int'(k == 0 && sck_tick));
            check("R7 chan_right", int'(chan_right), int'(ch && k >= n / 2));
            if (sck_tick) k = (k == n - 1) ? 0 : k + 1;
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        sck_tick = 1'b1;
        @(negedge clk);
        #1;
        check("R10 reset fs", int'(fs), 0);
        check("R10 reset bit_idx", int'(bit_idx), 0);
        check("R10 reset sof", int'(sof), 0);
        check("R10 reset chan_right", int'(chan_right), 0);
    endtask

    // R10: after a low-active run, disabling parks FS high
    task automatic t_disable();
        @(negedge clk);
        blk_en = 1'b0;
        sck_tick = 1'b1;
        @(negedge clk);
        #1;
        for (int c = 0; c < 4; c++) begin
            check("R10 idle fs", int'(fs), 1);
            check("R10 idle bit_idx", int'(bit_idx), 0);
            check("R10 idle sof", int'(sof), 0);
            check("R10 idle chan_right", int'(chan_right), 0);
            @(negedge clk);
            #1;
        end
    endtask

    initial begin
        t_reset();
        run_cfg(15, 0, 1'b0, 1'b1, 1'b0, 40, 1'b0, 1'b0, "R3 basic");
        run_cfg(15, 5, 1'b0, 1'b1, 1'b0, 40, 1'b0, 1'b0, "R3 width6");
        run_cfg(3, 2, 1'b0, 1'b1, 1'b0, 30, 1'b0, 1'b0, "R2 short");
        run_cfg(0, 0, 1'b0, 1'b1, 1'b0, 20, 1'b0, 1'b0, "R2 zero");
        run_cfg(15, 40, 1'b0, 1'b1, 1'b0, 40, 1'b0, 1'b0, "R4 clamp");
        run_cfg(31, 3, 1'b0, 1'b0, 1'b1, 80, 1'b0, 1'b0, "R5 R6 low lead");
        t_disable();
        run_cfg(31, 9, 1'b1, 1'b1, 1'b0, 80, 1'b0, 1'b0, "R7 chan");
        run_cfg(8, 0, 1'b1, 1'b0, 1'b1, 30, 1'b0, 1'b0, "R7 R6 chan odd");
        run_cfg(15, 2, 1'b0, 1'b1, 1'b0, 50, 1'b0, 1'b1, "R9 frozen");
        run_cfg(7, 0, 1'b0, 1'b1, 1'b1, 60, 1'b1, 1'b0, "R1 R6 gapped");
        run_cfg(255, 127, 1'b0, 1'b1, 1'b0, 520, 1'b0, 1'b0, "R3 R4 long");
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule